// File: doc/BRIEF.md
# Framed Status-Capture Serial Responder

This block answers a host over a two-wire serial link: the host drives a serial clock, and the block drives one data line back. Nothing is sent from the host to the block, and there is no select line. While the host keeps clocking, the block sends an endless train of fixed-length frames. Each frame opens with a run of zero bits, then a single one bit that marks alignment. After the marker comes a snapshot of a group of parallel status inputs. Because the zero run is longer than the payload, the host can find where each frame starts from the data alone.

The serial clock is sampled in the system clock domain through a synchronizer, and only its falling edges are used. Each falling edge moves a bit counter one step and loads the next bit into a registered output, so the line is settled before the host samples it on the next rising edge. The status inputs are copied into a holding register when a frame boundary passes and while reset is held. The payload bits therefore all come from one instant, even if the inputs move while the frame is being sent.

Top module: `status_frame_responder`

## Requirements
- R1: The serial clock passes through a two-flop synchronizer. The data line changes only on the third system clock edge after the serial clock falls, and it is not yet changed after the second.
- R2: A synchronous active-high reset puts the bit counter on bit 0 of a frame and drives the data line low. Once reset is released, the next frame starts from bit 0.
- R3: Bit positions 0 to PREAMBLE_LEN-1 of every frame are 0 (positions 0 to 19 with the defaults).
- R4: Bit position PREAMBLE_LEN is the marker and is always 1 (position 20 with the defaults).
- R5: Positions PREAMBLE_LEN+1 onward carry the snapshot most significant bit first. Position p carries snapshot bit (PREAMBLE_LEN+PAYLOAD_W-p), so with the defaults position 21 is bit 9 and position 30 is bit 0.
- R6: A frame is PREAMBLE_LEN+1+PAYLOAD_W bits long (31 with the defaults). The falling edge after the last position starts position 0 of the next frame, with no gap.
- R7: The snapshot is taken from the status inputs on the falling edge that ends a frame, and on every cycle while reset is held. Changes to the inputs at any other time have no effect on the frame being sent.
- R8: The data line holds its value while the serial clock stays high or stays low. Only a detected falling edge changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk_in | input | 1 | Serial clock from the host, asynchronous to clk |
| pins_in | input | PAYLOAD_W | Status inputs to be captured |
| sdo_out | output | 1 | Serial data line to the host, registered |

## Verification
The bench runs two copies of the block on one serial clock. The first uses a three-bit preamble and a four-bit payload, so each frame is eight bits long. At that size the run passes through all sixteen payload values many times, and it crosses far more frame wraps than the default size allows. The second copy keeps the default 20-zero, 10-bit layout, which checks the real bit positions and the MSB-first order. In each frame, the status inputs change in the middle of the payload, so the bench can show that the bits being sent still come from the earlier snapshot. A reset in the middle of a frame checks that counting restarts at bit 0.

// File: rtl/status_link_pkg.sv
package status_link_pkg;

  localparam int DEF_PREAMBLE_LEN = 20;
  localparam int DEF_PAYLOAD_W    = 10;
  localparam int DEF_SYNC_STAGES  = 2;

  typedef enum logic [1:0] {
    PH_PREAMBLE = 2'd0,
    PH_MARKER   = 2'd1,
    PH_PAYLOAD  = 2'd2
  } frame_phase_e;

  function automatic frame_phase_e phase_of(input int pos, input int pre_len);
    if (pos < pre_len)       return PH_PREAMBLE;
    else if (pos == pre_len) return PH_MARKER;
    else                     return PH_PAYLOAD;
  endfunction

endpackage

// File: rtl/sclk_edge_sync.sv
module sclk_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_in,
  output logic fall_o
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= 1'b0;
    else     chain_q[0] <= sclk_in;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[i] <= 1'b0;
      else     chain_q[i] <= chain_q[i-1];
    end
  end

  assign fall_o = chain_q[STAGES] & ~chain_q[STAGES-1];
endmodule

// File: rtl/frame_counter.sv
module frame_counter #(
  parameter int FRAME_LEN = 31,
  parameter int CNT_W     = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_next_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    if (!step_i)            cnt_next_o = cnt_q;
    else if (cnt_q == LAST) cnt_next_o = '0;
    else                    cnt_next_o = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_next_o;
  end

  assign wrap_o = step_i && (cnt_q == LAST);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/status_shifter.sv
module status_shifter
  import status_link_pkg::*;
#(
  parameter int PREAMBLE_LEN = 20,
  parameter int PAYLOAD_W    = 10,
  parameter int CNT_W        = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load_i,
  input  logic                 step_i,
  input  logic [PAYLOAD_W-1:0] pins_i,
  input  logic [CNT_W-1:0]     cnt_next_i,
  output logic [PAYLOAD_W-1:0] hold_o,
  output logic                 sdo_o
);
  localparam int IDX_W = (PAYLOAD_W > 1) ? $clog2(PAYLOAD_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PREAMBLE_LEN + PAYLOAD_W);

  logic [PAYLOAD_W-1:0] hold_q;
  logic [IDX_W-1:0]     pidx;
  logic                 bit_d;
  logic                 sdo_q;

  always_ff @(posedge clk) begin
    if (rst || load_i) hold_q <= pins_i;
  end

  assign pidx = IDX_W'(LAST - cnt_next_i);

  always_comb begin
    case (phase_of(int'(cnt_next_i), PREAMBLE_LEN))
      PH_PREAMBLE: bit_d = 1'b0;
      PH_MARKER:   bit_d = 1'b1;
      default:     bit_d = hold_q[pidx];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         sdo_q <= 1'b0;
    else if (step_i) sdo_q <= bit_d;
  end

  assign hold_o = hold_q;
  assign sdo_o  = sdo_q;
endmodule

// File: rtl/status_frame_responder.sv
module status_frame_responder
  import status_link_pkg::*;
#(
  parameter int PREAMBLE_LEN = DEF_PREAMBLE_LEN,
  parameter int PAYLOAD_W    = DEF_PAYLOAD_W,
  parameter int SYNC_STAGES  = DEF_SYNC_STAGES
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sclk_in,
  input  logic [PAYLOAD_W-1:0] pins_in,
  output logic                 sdo_out
);
  localparam int FRAME_LEN = PREAMBLE_LEN + 1 + PAYLOAD_W;
  localparam int CNT_W     = $clog2(FRAME_LEN);

  logic                 fall_w;
  logic                 wrap_w;
  logic [CNT_W-1:0]     cnt_w;
  logic [CNT_W-1:0]     cnt_next_w;
  logic [PAYLOAD_W-1:0] hold_w;

  sclk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .sclk_in (sclk_in),
    .fall_o  (fall_w)
  );

  frame_counter #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .step_i     (fall_w),
    .cnt_o      (cnt_w),
    .cnt_next_o (cnt_next_w),
    .wrap_o     (wrap_w)
  );

  status_shifter #(
    .PREAMBLE_LEN (PREAMBLE_LEN),
    .PAYLOAD_W    (PAYLOAD_W),
    .CNT_W        (CNT_W)
  ) u_shift (
    .clk        (clk),
    .rst        (rst),
    .load_i     (wrap_w),
    .step_i     (fall_w),
    .pins_i     (pins_in),
    .cnt_next_i (cnt_next_w),
    .hold_o     (hold_w),
    .sdo_o      (sdo_out)
  );
endmodule

// File: rtl/status_link_chk.sv
module status_link_chk #(
  parameter int PREAMBLE_LEN = 20,
  parameter int PAYLOAD_W    = 10,
  parameter int CNT_W        = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 fall,
  input logic [CNT_W-1:0]     cnt,
  input logic [PAYLOAD_W-1:0] hold,
  input logic                 sdo
);
  localparam int IDX_W = (PAYLOAD_W > 1) ? $clog2(PAYLOAD_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PREAMBLE_LEN + PAYLOAD_W);
  localparam logic [CNT_W-1:0] MARK = CNT_W'(PREAMBLE_LEN);

  logic rst_d;
  always_ff @(posedge clk) begin
    rst_d <= rst;
    // R2
    if (rst_d) reset_state_chk: assert (cnt == '0 && !sdo);
  end

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    fall |=> cnt == (($past(cnt) == LAST) ? '0 : $past(cnt) + CNT_W'(1)));

  // R8
  sdo_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fall |=> $stable(sdo) && $stable(cnt));

  // R3
  preamble_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt < MARK) |-> !sdo);

  // R4
  marker_one_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == MARK) |-> sdo);

  // R5
  payload_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt > MARK) |-> sdo == hold[IDX_W'(LAST - cnt)]);

  // R7
  snapshot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(fall && cnt == LAST) |=> $stable(hold));
endmodule

bind status_frame_responder status_link_chk #(
  .PREAMBLE_LEN (PREAMBLE_LEN),
  .PAYLOAD_W    (PAYLOAD_W),
  .CNT_W        (CNT_W)
) u_chk (
  .clk  (clk),
  .rst  (rst),
  .fall (fall_w),
  .cnt  (cnt_w),
  .hold (hold_w),
  .sdo  (sdo_out)
);

// File: tb/sim_status_frame_responder.sv
`timescale 1ns/1ps
module sim_status_frame_responder;
  localparam int S_PRE = 3;
  localparam int S_PW  = 4;
  localparam int S_FL  = S_PRE + 1 + S_PW;
  localparam int L_PRE = 20;
  localparam int L_PW  = 10;
  localparam int L_FL  = L_PRE + 1 + L_PW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic [S_PW-1:0] pins_s = '0;
  logic [L_PW-1:0] pins_l = '0;
  logic sdo_s, sdo_l;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  int k_s = 0, k_l = 0, f_s = 0, f_l = 0;
  logic [31:0] snap_s, snap_l;
  logic prev_s, prev_l;

  always #5 clk = ~clk;

  status_frame_responder #(.PREAMBLE_LEN(S_PRE), .PAYLOAD_W(S_PW)) u0 (
    .clk(clk), .rst(rst), .sclk_in(sclk), .pins_in(pins_s), .sdo_out(sdo_s));

  status_frame_responder #(.PREAMBLE_LEN(L_PRE), .PAYLOAD_W(L_PW)) u1 (
    .clk(clk), .rst(rst), .sclk_in(sclk), .pins_in(pins_l), .sdo_out(sdo_l));

  function automatic logic exp_bit(int k, int pre, int pw, logic [31:0] snap);
    if (k < pre)  return 1'b0;
    if (k == pre) return 1'b1;
    return snap[pre + pw - k];
  endfunction

  function automatic string req_of(int k, int pre);
    if (k == 0)   return "R6";
    if (k < pre)  return "R3";
    if (k == pre) return "R4";
    return "R5/R7";
  endfunction

  function automatic logic [L_PW-1:0] pat_l(int f);
    if (f % 7 == 1) return '1;
    if (f % 7 == 2) return '0;
    if (f % 7 == 3) return 10'h2AA;
    return L_PW'(f * 293 + 16'h155);
  endfunction

  task automatic check(string req, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b (time %0t)", req, act, exp, $time);
    end
  endtask

  task automatic do_bit();
    logic e_s, e_l;
    e_s = exp_bit(k_s, S_PRE, S_PW, snap_s);
    e_l = exp_bit(k_l, L_PRE, L_PW, snap_l);
    check({"R8 small ", req_of(k_s, S_PRE)}, sdo_s, e_s);
    check({"R8 default ", req_of(k_l, L_PRE)}, sdo_l, e_l);
    prev_s = e_s;
    prev_l = e_l;
    // R7: move the inputs while the current payload is still going out
    if (k_s == S_PRE + 1) pins_s = S_PW'(f_s + 1);
    if (k_l == L_PRE + 2) pins_l = pat_l(f_l + 1);
    if (k_s == S_FL - 1) begin snap_s = 32'(pins_s); f_s++; end
    if (k_l == L_FL - 1) begin snap_l = 32'(pins_l); f_l++; end
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    // R8: a high serial clock leaves the line unchanged
    check("R8 small high", sdo_s, prev_s);
    check("R8 default high", sdo_l, prev_l);
    sclk = 1'b0;
    repeat (2) @(negedge clk);
    // R1: two edges after the fall the line has not moved yet
    check("R1 small", sdo_s, prev_s);
    check("R1 default", sdo_l, prev_l);
    @(negedge clk);
    k_s = (k_s + 1) % S_FL;
    k_l = (k_l + 1) % L_FL;
  endtask

  task automatic apply_reset(logic [S_PW-1:0] ps, logic [L_PW-1:0] pl);
    @(negedge clk);
    rst = 1'b1;
    pins_s = ps;
    pins_l = pl;
    repeat (3) @(negedge clk);
    snap_s = 32'(ps);
    snap_l = 32'(pl);
    rst = 1'b0;
    @(negedge clk);
    k_s = 0;
    k_l = 0;
    // R2
    check("R2 small reset", sdo_s, 1'b0);
    check("R2 default reset", sdo_l, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    f_s = 0;
    f_l = 0;
    apply_reset('0, pat_l(0));
    for (int i = 0; i < 700; i++) do_bit();
    // R2: reset in the middle of a frame restarts at bit 0
    f_s = 5;
    f_l = 3;
    apply_reset(4'hA, 10'h1C3);
    for (int i = 0; i < 600; i++) do_bit();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule